// File: doc/BRIEF.md
# Dual-Slope ADC Sequencer

This block is the digital half of a dual-slope integrating converter. The integrator, comparator and analog switches sit outside it. The block selects what the integrator sees: ground, the unknown input or the reference. It also drives the auto-zero switch, counts clock periods, and reports the converted value.

While idle, the block keeps the integrator in auto-zero with its input grounded. A START request begins a conversion. First the input is integrated for a fixed window of 2^N_BITS clocks. Then the reference is applied, and the block counts until the comparator output changes. That count is the result, and it is proportional to the input over the reference. The comparator output is asynchronous to the block clock, so it passes through a two-flop synchronizer, and any change of the synchronized level counts as the toggle. If no toggle arrives within the longest allowed de-integrate window, the block reports a saturated result and flags overrange. After every conversion the block goes back to auto-zero and holds the result and the end flag until the next START.

Top module: `dslope_seq`

## Requirements
- R1: After reset, and whenever no conversion is running, `sel_o` is 2'b00 (ground) and `az_o` is 1. Reset clears `result_o`, `eoc_o` and `ovr_o` to 0.
- R2: If `start_i` is high at a clock edge while idle, then from that edge `sel_o` is 2'b01 (signal), `az_o` is 0, and `eoc_o` and `ovr_o` are 0.
- R3: `sel_o` stays 2'b01 for exactly 2^N_BITS clock cycles. It then changes directly to 2'b10 (reference) for the de-integrate phase.
- R4: A change of `cmp_i` sampled at clock edge k is recognised at edge k+2, in either direction, through a two-flop synchronizer plus an edge detector. Only a recognition that falls inside the de-integrate phase ends the conversion. Changes recognised while idle or integrating are ignored.
- R5: When a recognised toggle ends the de-integrate phase at its m-th clock edge, `result_o` becomes m-1. This is the number of de-integrate edges before the terminating one, so a toggle sampled j edges into de-integrate gives j+1.
- R6: If no toggle has been recognised by the 2^N_BITS-th de-integrate edge, that edge sets `result_o` to all ones and `ovr_o` to 1. A toggle recognised at that same edge takes priority and gives all ones with `ovr_o` 0.
- R7: The edge that ends a conversion sets `eoc_o` to 1 and returns to the idle state (`sel_o` 2'b00, `az_o` 1). `eoc_o`, `result_o` and `ovr_o` then hold until the next accepted START.
- R8: `start_i` is ignored while integrating or de-integrating. The phase lengths and the result are the same as without the extra request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Asynchronous comparator output from the integrator |
| sel_o | output | 2 | Integrator input select: 00 ground, 01 signal, 10 reference |
| az_o | output | 1 | Auto-zero switch closed when 1 |
| result_o | output | N_BITS | Captured de-integrate count |
| eoc_o | output | 1 | End of conversion, held until next START |
| ovr_o | output | 1 | Overrange: de-integrate window exhausted |

## Verification
A behavioural ramp drives the comparator. The input is added during integrate, the reference is subtracted during de-integrate, and the ramp is cleared in auto-zero, so each result must equal the input plus one. The bench targets the two ends of the de-integrate window. An input of 254 makes the toggle coincide with the final count: a design that gives the saturation branch priority would wrongly flag overrange there. Inputs of 255 and 0 never toggle in time, and a design without the bound would count on forever or wrap to a small value. Hand-driven comparator steps and one-cycle pulses check the two-edge synchronizer latency and detection in either direction: an extra or missing flop shifts every result by one, and a level test in place of an edge test misses the pulse. Stray START requests inside a conversion and START held high continuously expose a sequencer that restarts or stretches its integrate window.

// File: rtl/dslope_seq.sv
module dslope_seq #(
  parameter int N_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_i,
  output logic [1:0]        sel_o,
  output logic              az_o,
  output logic [N_BITS-1:0] result_o,
  output logic              eoc_o,
  output logic              ovr_o
);

  localparam logic [1:0] SEL_GND = 2'b00;
  localparam logic [1:0] SEL_SIG = 2'b01;
  localparam logic [1:0] SEL_REF = 2'b10;

  typedef enum logic [1:0] {ST_ZERO, ST_INT, ST_DEINT} st_t;

  st_t              st;
  logic [N_BITS-1:0] cnt;
  logic [2:0]       cmp_sync;

  wire at_top   = &cnt;
  wire cmp_edge = cmp_sync[1] ^ cmp_sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_sync <= '0;
    else        cmp_sync <= {cmp_sync[1:0], cmp_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_ZERO;
      cnt      <= '0;
      result_o <= '0;
      eoc_o    <= 1'b0;
      ovr_o    <= 1'b0;
    end else begin
      case (st)
        ST_ZERO: begin
          if (start_i) begin
            st    <= ST_INT;
            cnt   <= '0;
            eoc_o <= 1'b0;
            ovr_o <= 1'b0;
          end
        end
        ST_INT: begin
          cnt <= cnt + 1'b1;
          if (at_top) st <= ST_DEINT;
        end
        ST_DEINT: begin
          if (cmp_edge) begin
            result_o <= cnt;
            eoc_o    <= 1'b1;
            st       <= ST_ZERO;
          end else if (at_top) begin
            result_o <= '1;
            ovr_o    <= 1'b1;
            eoc_o    <= 1'b1;
            st       <= ST_ZERO;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_ZERO;
      endcase
    end
  end

  assign az_o = (st == ST_ZERO);

  always_comb begin
    case (st)
      ST_INT:   sel_o = SEL_SIG;
      ST_DEINT: sel_o = SEL_REF;
      default:  sel_o = SEL_GND;
    endcase
  end

endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int N_BITS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        sel_o,
  input logic              az_o,
  input logic [N_BITS-1:0] result_o,
  input logic              eoc_o,
  input logic              ovr_o
);

  int sig_run;
  int ref_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_run <= 0;
      ref_run <= 0;
    end else begin
      sig_run <= (sel_o == 2'b01) ? sig_run + 1 : 0;
      ref_run <= (sel_o == 2'b10) ? ref_run + 1 : 0;
    end
  end

  assert_integ_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == 2'b10 && $past(sel_o) == 2'b01) |-> sig_run == 2**N_BITS);

  assert_integ_to_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_o) == 2'b01 && sel_o != 2'b01) |-> sel_o == 2'b10);

  assert_deint_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == 2'b10) |-> ref_run < 2**N_BITS);

  assert_ovr_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> &result_o);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (az_o && start_i) |=> (sel_o == 2'b01 && !az_o && !eoc_o && !ovr_o));

  assert_eoc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_o && !start_i) |=> (eoc_o && $stable(result_o) && $stable(ovr_o)));

  assert_end_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_o) |-> (az_o && sel_o == 2'b00));

  assert_busy_noeoc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !az_o |-> !eoc_o);

endmodule

bind dslope_seq dslope_seq_chk #(.N_BITS(N_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_o(sel_o), .az_o(az_o),
  .result_o(result_o), .eoc_o(eoc_o), .ovr_o(ovr_o)
);

// File: tb/tb_dslope_seq.sv
module tb_dslope_seq;
  localparam int NB   = 8;
  localparam int FULL = 1 << NB;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, cmp_i = 1'b0;
  logic [1:0] sel_o;
  logic az_o, eoc_o, ovr_o;
  logic [NB-1:0] result_o;

  always #10 clk = ~clk;

  dslope_seq #(.N_BITS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .sel_o(sel_o), .az_o(az_o), .result_o(result_o), .eoc_o(eoc_o), .ovr_o(ovr_o)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit ramp_en = 1'b0;
  int vin = 0, acc = 0, sig_cnt = 0, last_sig = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // behavioural reference: phase 0 idle, 1 integrate, 2 de-integrate
  int m_phase = 0, m_el = 0, m_res = 0;
  bit m_eoc = 0, m_ovr = 0;
  bit hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL R7 watchdog: actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
    if (!rst_n) begin
      m_phase = 0; m_el = 0; m_res = 0; m_eoc = 0; m_ovr = 0;
      hist = '{0, 0, 0};
    end else begin
      bit seen;
      seen = (hist[1] != hist[2]);
      hist.push_front(cmp_i);
      void'(hist.pop_back());
      if (m_phase == 0) begin
        if (start_i) begin m_phase = 1; m_el = 0; m_eoc = 0; m_ovr = 0; end
      end else if (m_phase == 1) begin
        m_el++;
        if (m_el == FULL) begin m_phase = 2; m_el = 0; end
      end else begin
        m_el++;
        if (seen) begin m_res = m_el - 1; m_eoc = 1; m_phase = 0; end
        else if (m_el == FULL) begin m_res = FULL - 1; m_ovr = 1; m_eoc = 1; m_phase = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      string rq;
      rq = (m_phase == 0) ? "R1" : "R3";
      chk(sel_o == m_phase[1:0], rq, "sel_o", sel_o, m_phase);
      chk(az_o == (m_phase == 0), rq, "az_o", az_o, m_phase == 0);
      chk(result_o == m_res[NB-1:0], "R5", "result_o", result_o, m_res);
      chk(ovr_o == m_ovr, "R6", "ovr_o", ovr_o, m_ovr);
      chk(eoc_o == m_eoc, "R7", "eoc_o", eoc_o, m_eoc);
      if (sel_o == 2'b01) sig_cnt++;
      else if (sig_cnt != 0) begin last_sig = sig_cnt; sig_cnt = 0; end
      if (ramp_en) begin
        if (az_o) acc = 0;
        else if (sel_o == 2'b01) acc += vin;
        else if (sel_o == 2'b10) acc -= FULL;
        cmp_i = (acc > 0);
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_eoc();
    while (!eoc_o) @(negedge clk);
  endtask

  task automatic wait_ref();
    while (sel_o != 2'b10) @(negedge clk);
  endtask

  task automatic conv(input int v, input int er, input bit eo, input string rq);
    ramp_en = 1'b1; vin = v;
    pulse_start();
    wait_eoc();
    chk(result_o == er[NB-1:0], rq, "ramp result", result_o, er);
    chk(ovr_o == eo, "R6", "ramp overrange", ovr_o, eo);
    chk(last_sig == FULL, "R3", "integrate length", last_sig, FULL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_o == 2'b00 && az_o == 1'b1, "R1", "idle switches", {sel_o, az_o}, 1);
    chk(result_o == 0 && eoc_o == 0 && ovr_o == 0, "R1", "reset outputs", {result_o, eoc_o, ovr_o}, 0);

    conv(100, 101, 0, "R5");
    conv(37, 38, 0, "R5");
    conv(254, 255, 0, "R6");
    conv(255, 255, 1, "R6");
    conv(0, 255, 1, "R6");
    conv(10, 11, 0, "R2");

    // R7: hold after completion
    repeat (30) @(negedge clk);
    chk(eoc_o == 1 && result_o == 11, "R7", "held eoc/result", result_o, 11);
    chk(az_o == 1 && sel_o == 2'b00, "R7", "idle after eoc", az_o, 1);

    // R8: stray start requests during both phases
    vin = 50;
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    wait_ref();
    repeat (10) @(negedge clk);
    pulse_start();
    wait_eoc();
    chk(result_o == 51, "R8", "result with stray start", result_o, 51);
    chk(last_sig == FULL, "R8", "integrate length with stray start", last_sig, FULL);

    // R4: hand-driven comparator step, sampled 5 edges into de-integrate
    ramp_en = 1'b0;
    @(negedge clk); cmp_i = 1'b1;
    repeat (5) @(negedge clk);
    pulse_start();
    wait_ref();
    repeat (4) @(negedge clk);
    cmp_i = 1'b0;
    wait_eoc();
    chk(result_o == 6, "R4", "step latency result", result_o, 6);

    // R4: one-cycle pulse, rising at the 3rd de-integrate sample
    pulse_start();
    wait_ref();
    repeat (2) @(negedge clk);
    cmp_i = 1'b1;
    @(negedge clk);
    cmp_i = 1'b0;
    wait_eoc();
    chk(result_o == 4, "R4", "pulse detection result", result_o, 4);

    // R2: start held high for back-to-back conversions
    ramp_en = 1'b1; vin = 20;
    @(negedge clk); start_i = 1'b1;
    repeat (700) @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    wait_eoc();
    chk(result_o == 21, "R2", "back-to-back result", result_o, 21);

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule